// File: doc/BRIEF.md
# Burst Bridge Pulse Generator

This block drives the two legs of a full-bridge for a short, counted burst of switching periods while the converter is still held off, so the reflected input voltage can be measured on the secondary side before normal operation starts. A start request loads a configuration snapshot and launches a tick counter that runs from zero up to the programmed period minus one. Within each period, leg A is driven high across one compare window and leg B across a second window, typically half a period later. Two pulses are sent because the first one may not fully enhance the floating high-side switch.

A single-cycle sample strobe for the ADC fires at a programmable count inside one chosen period of the burst. The count is normally placed late in the leg A pulse, clear of the ringing after the rising edge. The chosen period is given as a distance from the end of the burst, so the default of zero selects the last period. When the last period ends, a one-clock done pulse is raised. Supervisory logic calls the block again at intervals until the sensed voltage clears the undervoltage threshold. Typical settings are a period of 20000, leg A at 20..2625, leg B at 10020..12625, and a sample count of 2400.

Top module: `burst_pulse_gen`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, drv_a_o, drv_b_o, samp_o and done_o are all 0.
- R2: A start_i seen high at a rising edge while idle, with burst_len_i nonzero, begins a burst of burst_len_i periods. Each period lasts period_i clocks (period_i of 2 or more), with the tick count running 0 to period_i-1.
- R3: After the edge that accepts a start, at edge t (t >= 1, t-1 inside the burst), drv_a_o is 1 exactly when the count (t-1) mod period_i lies in [rise_a_i, fall_a_i).
- R4: drv_b_o follows the same rule as R3, using the window [rise_b_i, fall_b_i).
- R5: samp_o is high for one clock after the edge where the count equals samp_cnt_i in period number burst_len_i-1-meas_back_i, with periods numbered from 0. meas_back_i = 0 selects the last period. If meas_back_i >= burst_len_i, no strobe is produced.
- R6: done_o is 1 for exactly one clock, after edge burst_len_i*period_i counted from the accepting edge (edge 0).
- R7: While a burst runs, start_i is ignored. All configuration inputs are sampled only at the accepting edge, so changing them during a burst has no effect on that burst.
- R8: A start with burst_len_i = 0 is ignored: no output is driven high.
- R9: Outside a burst, all outputs are 0. A new start is accepted from the edge after the one that raises done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Burst request |
| period_i | input | 16 | Period length in clocks |
| rise_a_i | input | 16 | Leg A window start count |
| fall_a_i | input | 16 | Leg A window end count (exclusive) |
| rise_b_i | input | 16 | Leg B window start count |
| fall_b_i | input | 16 | Leg B window end count (exclusive) |
| samp_cnt_i | input | 16 | Sample strobe count |
| burst_len_i | input | 4 | Number of periods per burst |
| meas_back_i | input | 4 | Sampled period, counted back from the last |
| drv_a_o | output | 1 | Leg A drive |
| drv_b_o | output | 1 | Leg B drive |
| samp_o | output | 1 | ADC sample strobe |
| done_o | output | 1 | Burst complete pulse |

## Verification
Each output is registered from the tick counter, so a drive or strobe decision made at count c shows up one edge later. If the start is taken at edge 0, the count at edge t is (t-1) mod period. The done pulse follows edge burst_len*period. The bench numbers the edges from the accepting one, computes the expected value of all four outputs for every edge from the window rules, and samples on the falling edge. Restarts and configuration changes are injected at least two edges before the burst ends, so they land while the burst is still running.

// File: rtl/bpg_pkg.sv
package bpg_pkg;
  localparam int CNT_W    = 16;
  localparam int BURST_W  = 4;
  localparam int NUM_LEGS = 2;

  typedef logic [CNT_W-1:0]   cnt_t;
  typedef logic [BURST_W-1:0] bcnt_t;

  typedef struct packed {
    cnt_t rise;
    cnt_t fall;
  } leg_win_t;
endpackage

// File: rtl/bpg_timebase.sv
module bpg_timebase
  import bpg_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  cnt_t  period_i,
  input  bcnt_t len_i,
  output logic  accept_o,
  output logic  busy_o,
  output cnt_t  cnt_o,
  output bcnt_t idx_o,
  output logic  done_o
);
  logic  busy_q, done_q;
  cnt_t  cnt_q, per_q;
  bcnt_t idx_q, len_q;
  logic  last_tick, last_per;

  assign accept_o  = start_i && !busy_q && (len_i != '0);
  assign last_tick = (cnt_q == per_q - cnt_t'(1));
  assign last_per  = (idx_q == len_q - bcnt_t'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      per_q  <= '0;
      idx_q  <= '0;
      len_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (accept_o) begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
          idx_q  <= '0;
          per_q  <= period_i;
          len_q  <= len_i;
        end
      end else if (last_tick) begin
        cnt_q <= '0;
        if (last_per) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + bcnt_t'(1);
        end
      end else begin
        cnt_q <= cnt_q + cnt_t'(1);
      end
    end
  end

  assign busy_o = busy_q;
  assign cnt_o  = cnt_q;
  assign idx_o  = idx_q;
  assign done_o = done_q;
endmodule

// File: rtl/bpg_edge_cmp.sv
module bpg_edge_cmp
  import bpg_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     load_i,
  input  leg_win_t win_i,
  input  logic     busy_i,
  input  cnt_t     cnt_i,
  output logic     drv_o
);
  leg_win_t win_q;
  logic     drv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
      drv_q <= 1'b0;
    end else begin
      if (load_i) win_q <= win_i;
      drv_q <= busy_i && (cnt_i >= win_q.rise) && (cnt_i < win_q.fall);
    end
  end

  assign drv_o = drv_q;
endmodule

// File: rtl/bpg_sample_gate.sv
module bpg_sample_gate
  import bpg_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  cnt_t  samp_cnt_i,
  input  bcnt_t len_i,
  input  bcnt_t back_i,
  input  logic  busy_i,
  input  cnt_t  cnt_i,
  input  bcnt_t idx_i,
  output logic  samp_o
);
  cnt_t  samp_q;
  bcnt_t tgt_q;
  logic  arm_q, samp_r;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q <= '0;
      tgt_q  <= '0;
      arm_q  <= 1'b0;
      samp_r <= 1'b0;
    end else begin
      if (load_i) begin
        samp_q <= samp_cnt_i;
        tgt_q  <= len_i - bcnt_t'(1) - back_i;
        arm_q  <= (back_i < len_i);
      end
      samp_r <= busy_i && arm_q && (idx_i == tgt_q) && (cnt_i == samp_q);
    end
  end

  assign samp_o = samp_r;
endmodule

// File: rtl/burst_pulse_gen.sv
module burst_pulse_gen
  import bpg_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [CNT_W-1:0]     period_i,
  input  logic [CNT_W-1:0]     rise_a_i,
  input  logic [CNT_W-1:0]     fall_a_i,
  input  logic [CNT_W-1:0]     rise_b_i,
  input  logic [CNT_W-1:0]     fall_b_i,
  input  logic [CNT_W-1:0]     samp_cnt_i,
  input  logic [BURST_W-1:0]   burst_len_i,
  input  logic [BURST_W-1:0]   meas_back_i,
  output logic                 drv_a_o,
  output logic                 drv_b_o,
  output logic                 samp_o,
  output logic                 done_o
);
  logic     accept, busy;
  cnt_t     cnt;
  bcnt_t    idx;
  leg_win_t leg_win [NUM_LEGS];
  logic     leg_drv [NUM_LEGS];

  bpg_timebase u_tb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .period_i (period_i),
    .len_i    (burst_len_i),
    .accept_o (accept),
    .busy_o   (busy),
    .cnt_o    (cnt),
    .idx_o    (idx),
    .done_o   (done_o)
  );

  assign leg_win[0] = '{rise: rise_a_i, fall: fall_a_i};
  assign leg_win[1] = '{rise: rise_b_i, fall: fall_b_i};

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    bpg_edge_cmp u_cmp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (accept),
      .win_i  (leg_win[g]),
      .busy_i (busy),
      .cnt_i  (cnt),
      .drv_o  (leg_drv[g])
    );
  end

  assign drv_a_o = leg_drv[0];
  assign drv_b_o = leg_drv[1];

  bpg_sample_gate u_smp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .samp_cnt_i (samp_cnt_i),
    .len_i      (burst_len_i),
    .back_i     (meas_back_i),
    .busy_i     (busy),
    .cnt_i      (cnt),
    .idx_i      (idx),
    .samp_o     (samp_o)
  );
endmodule

// File: rtl/bpg_checker.sv
module bpg_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_i,
  input logic drv_a_i,
  input logic drv_b_i,
  input logic samp_i,
  input logic done_i
);
  // R3, R9: leg A only driven from an active burst
  a_r3_drv_a_in_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_a_i |-> $past(busy_i));
  // R4, R9
  a_r4_drv_b_in_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_b_i |-> $past(busy_i));
  // R5
  a_r5_samp_in_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    samp_i |-> $past(busy_i));
  // R6
  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);
  // R6
  a_r6_done_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> ($past(busy_i) && !busy_i));
  // R2, R7
  a_r2_start_begins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(start_i));
endmodule

bind burst_pulse_gen bpg_checker u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_i  (busy),
  .drv_a_i (drv_a_o),
  .drv_b_i (drv_b_o),
  .samp_i  (samp_o),
  .done_i  (done_o)
);

// File: tb/sim_burst_pulse_gen.sv
`timescale 1ns/1ps
module sim_burst_pulse_gen;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start = 1'b0;
  logic [15:0] period = '0, rise_a = '0, fall_a = '0, rise_b = '0, fall_b = '0, samp_cnt = '0;
  logic [3:0]  blen = '0, back = '0;
  logic        drv_a, drv_b, samp, done;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  int cp, cn, ra, fa, rb, fb, cs, cbk;

  always #5 clk = ~clk;

  burst_pulse_gen u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start),
    .period_i(period), .rise_a_i(rise_a), .fall_a_i(fall_a),
    .rise_b_i(rise_b), .fall_b_i(fall_b), .samp_cnt_i(samp_cnt),
    .burst_len_i(blen), .meas_back_i(back),
    .drv_a_o(drv_a), .drv_b_o(drv_b), .samp_o(samp), .done_o(done)
  );

  // expected {done, samp, drv_b, drv_a} after edge t (edge 0 accepts start)
  function automatic logic [3:0] expv(int t);
    logic [3:0] e = '0;
    if (t >= 1 && t - 1 < cn * cp) begin
      int c = (t - 1) % cp;
      int q = (t - 1) / cp;
      e[0] = (c >= ra) && (c < fa);
      e[1] = (c >= rb) && (c < fb);
      e[2] = (cbk < cn) && (q == cn - 1 - cbk) && (c == cs);
    end
    e[3] = (t == cn * cp);
    return e;
  endfunction

  task automatic chk(int t, logic [3:0] e, string tag);
    logic [3:0] g = {done, samp, drv_b, drv_a};
    checks++;
    if (g !== e) begin
      string r;
      fails++;
      if (tag != "") r = tag;
      else if (g[3] !== e[3]) r = "R6";
      else if (t == 0 || t - 1 >= cn * cp) r = "R9";
      else if (g[2] !== e[2]) r = "R5";
      else if (g[1] !== e[1]) r = "R4";
      else r = "R3";
      $display("FAIL %s t=%0d got=%b exp=%b", r, t, g, e);
    end
  endtask

  task automatic run_burst(int p, int n, int a0, int a1, int b0, int b1, int s, int bk, int inj);
    @(negedge clk);
    cp = p; cn = n; ra = a0; fa = a1; rb = b0; fb = b1; cs = s; cbk = bk;
    period = 16'(p); blen = 4'(n); rise_a = 16'(a0); fall_a = 16'(a1);
    rise_b = 16'(b0); fall_b = 16'(b1); samp_cnt = 16'(s); back = 4'(bk);
    start = 1'b1;
    @(posedge clk);
    for (int t = 0; t <= n * p + 2; t++) begin
      @(negedge clk);
      chk(t, expv(t), "");
      if (t == 0) start = 1'b0;
      if (t == inj) begin
        // R7: restart and config changes mid-burst must be ignored
        start = 1'b1;
        period = 16'($urandom_range(2, 60)); blen = 4'($urandom_range(1, 15));
        rise_a = 16'($urandom); fall_a = 16'($urandom);
        rise_b = 16'($urandom); fall_b = 16'($urandom);
        samp_cnt = 16'($urandom_range(0, 5)); back = 4'($urandom_range(0, 3));
      end
      if (t == inj + 1) start = 1'b0;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R6 watchdog expired got=hung exp=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    cn = 1; cp = 1;
    repeat (3) begin
      @(negedge clk);
      chk(-1, 4'b0, "R1");
    end
    rst_ni = 1'b1;
    @(negedge clk);
    chk(-1, 4'b0, "R1");

    // R8: zero-length burst
    @(negedge clk);
    blen = 4'd0; period = 16'd10; rise_a = 16'd0; fall_a = 16'd5; start = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      start = 1'b0;
      chk(-1, 4'b0, "R8");
    end

    // R2, R3, R4, R5: nominal settings, last period sampled
    run_burst(20000, 2, 20, 2625, 10020, 12625, 2400, 0, -1);
    // R5: first period sampled, R7 restart injected
    run_burst(40, 3, 2, 13, 22, 33, 12, 2, 50);
    // R5: selection beyond burst gives no strobe
    run_burst(16, 2, 1, 6, 9, 14, 5, 2, 10);
    // boundary windows: rise at 0, fall at period end
    run_burst(8, 1, 0, 4, 4, 8, 0, 0, -1);
    // R2: minimum period
    run_burst(2, 4, 0, 1, 1, 2, 1, 1, 3);

    for (int k = 0; k < 30; k++) begin
      int p = $urandom_range(6, 40);
      int n = $urandom_range(1, 4);
      int h = p / 2;
      int a0 = $urandom_range(0, h - 2);
      int a1 = $urandom_range(a0 + 1, h);
      int s = $urandom_range(a0, a1 - 1);
      int bk = $urandom_range(0, 4);
      int inj = ($urandom_range(0, 1) == 1) ? $urandom_range(1, n * p - 2) : -1;
      run_burst(p, n, a0, a1, a0 + h, a1 + h, s, bk, inj);
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule